// File: doc/BRIEF.md
# Watchdog Timer with Register Interface

This block is a memory-mapped watchdog. A 32-bit counter runs down from a programmable reload value, one step per count tick. When the counter lands on zero, a sticky status flag is raised and up to three pulse outputs fire: a reset request, an interrupt and an external signal. Each output has its own enable bit. Software keeps the system alive by writing a fixed key word to the restart register, which reloads the counter before it expires.

The count tick comes either from the bus clock, giving one tick per cycle, or from a slower external clock. The external clock is synchronised into the bus domain and its rising edges are detected there. All three pulses share one 8-bit length register. A small two-state machine stretches each expiry into a pulse of programmable width. Its states are IDLE and ACTIVE. The transition IDLE to ACTIVE (named fire) happens when the counter reaches zero. The transition ACTIVE to IDLE (named expire) happens when the pulse down-count is exhausted.

Register offsets (byte addresses, 32-bit words): counter 0x00, reload 0x04, restart 0x08, control 0x0C, status 0x10, status-clear 0x14, pulse length 0x18. The control fields are:
- bit 0: run
- bit 1: reset-output enable
- bit 2: interrupt-output enable
- bit 3: external-output enable
- bit 4: count clock select (0 = bus clock, 1 = external clock)

Top module: `wdog_timer`

## Requirements
- R1: After reset, the reload register and the counter both read 0x03EF1480, the pulse length reads 0xFF, and control and status read 0. All three pulse outputs are low.
- R2: A write of exactly 0x5AB9 (all 32 bits compared) to offset 0x08 loads the reload value into the counter on that clock edge. Any other value written there leaves the counter unchanged.
- R3: While control bit 0 is 1, the counter decreases by one per tick. While control bit 0 is 0, the counter holds its value.
- R4: Once the counter reaches zero, it stays at zero until a valid restart occurs. Writes to offset 0x00 are ignored.
- R5: Status bit 0 (offset 0x10) becomes 1 on the edge where the counter reaches zero. Writing 1 to bit 0 of offset 0x14 clears it. Writing 0 there has no effect.
- R6: Control bits 1, 2 and 3 enable the reset, interrupt and external outputs respectively; these enables are sampled when the counter reaches zero. An enabled output is high from the cycle in which the counter first reads zero, for (pulse length + 1) bus cycles.
- R7: Each arrival at zero produces exactly one pulse. A counter held at zero produces no further pulses.
- R8: With control bit 4 set to 1, the counter decreases once per rising edge of ext_clk. Each decrement occurs on the second bus edge after the edge that first samples ext_clk high. While ext_clk is steady, the counter holds.
- R9: Unused register bits read 0. Only bits 7:0 of the pulse length are kept, and only bits 4:0 of control. Any address other than the seven listed offsets reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_clk | input | 1 | Optional slow count clock, asynchronous |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register byte address |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for addr, combinational |
| rst_pulse | output | 1 | Reset request pulse |
| irq_pulse | output | 1 | Interrupt pulse |
| ext_pulse | output | 1 | External signal pulse |

## Verification
The hardest situation to reach is the exact alignment of the zero arrival, the status flag and the pulse window against the tick source. This matters most when the tick comes from the synchronised external clock, where the decrement trails the input edge by the synchroniser depth. The bench reaches it with small reload values (1 to 5) and short pulse lengths (0 to 3). It sweeps every combination while rotating through all eight output-enable masks. In every cycle of each run it compares the counter, status and pulses against arithmetic predictions. The external-clock case is driven with slow, hand-timed ext_clk edges. After each burst, the bench checks the counter against the edge count.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int ADDR_W = 8;
    localparam int WORD_W = 32;

    localparam logic [ADDR_W-1:0] OFF_COUNT   = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_RELOAD  = 8'h04;
    localparam logic [ADDR_W-1:0] OFF_RESTART = 8'h08;
    localparam logic [ADDR_W-1:0] OFF_CTRL    = 8'h0C;
    localparam logic [ADDR_W-1:0] OFF_STATUS  = 8'h10;
    localparam logic [ADDR_W-1:0] OFF_CLEAR   = 8'h14;
    localparam logic [ADDR_W-1:0] OFF_LEN     = 8'h18;

    typedef enum logic [0:0] {
        PS_IDLE   = 1'b0,
        PS_ACTIVE = 1'b1
    } pulse_state_t;

    typedef struct packed {
        logic clk_sel;
        logic ext_en;
        logic irq_en;
        logic rst_en;
        logic run;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/wdog_tick_gen.sv
module wdog_tick_gen #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_clk,
    input  logic use_ext,
    output logic tick
);
    localparam int TOP = SYNC_STAGES - 1;

    logic [TOP:0] sync_q;
    logic         last_q;

    generate
        if (SYNC_STAGES > 1) begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    sync_q <= '0;
                end else begin
                    sync_q <= {sync_q[TOP-1:0], ext_clk};
                end
            end
        end else begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    sync_q <= '0;
                end else begin
                    sync_q <= ext_clk;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_q <= 1'b0;
        end else begin
            last_q <= sync_q[TOP];
        end
    end

    // Bus clock gives a tick every cycle; external clock gives one per rising edge.
    assign tick = use_ext ? (sync_q[TOP] & ~last_q) : 1'b1;

endmodule

// File: rtl/wdog_countdown.sv
module wdog_countdown #(
    parameter int               CNT_W = 32,
    parameter logic [CNT_W-1:0] INIT  = 32'h03EF1480
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] reload,
    input  logic             restart,
    input  logic             run,
    input  logic             tick,
    output logic [CNT_W-1:0] count,
    output logic             hit
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic step;

    assign step = run & tick & (count != '0) & ~restart;
    assign hit  = step & (count == ONE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= INIT;
        end else if (restart) begin
            count <= reload;
        end else if (step) begin
            count <= count - ONE;
        end
    end

endmodule

// File: rtl/wdog_pulse_fsm.sv
module wdog_pulse_fsm
    import wdog_pkg::*;
#(
    parameter int LEN_W = 8,
    parameter int N_OUT = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire,
    input  logic [LEN_W-1:0] len,
    input  logic [N_OUT-1:0] en_mask,
    output logic [N_OUT-1:0] pulses
);
    pulse_state_t     state_q, state_d;
    logic [LEN_W-1:0] remain_q, remain_d;
    logic [N_OUT-1:0] mask_q, mask_d;

    always_comb begin
        state_d  = state_q;
        remain_d = remain_q;
        mask_d   = mask_q;
        unique case (state_q)
            PS_IDLE: begin
                if (fire) begin
                    state_d  = PS_ACTIVE;
                    remain_d = len;
                    mask_d   = en_mask;
                end
            end
            PS_ACTIVE: begin
                if (remain_q == '0) begin
                    state_d = PS_IDLE;
                end else begin
                    remain_d = remain_q - 1'b1;
                end
            end
            default: state_d = PS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= PS_IDLE;
            remain_q <= '0;
            mask_q   <= '0;
        end else begin
            state_q  <= state_d;
            remain_q <= remain_d;
            mask_q   <= mask_d;
        end
    end

    always_comb begin
        pulses = (state_q == PS_ACTIVE) ? mask_q : '0;
    end

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
    import wdog_pkg::*;
#(
    parameter int                CNT_W       = 32,
    parameter int                LEN_W       = 8,
    parameter int                SYNC_STAGES = 2,
    parameter logic [CNT_W-1:0]  RELOAD_INIT = 32'h03EF1480,
    parameter logic [LEN_W-1:0]  LEN_INIT    = 8'hFF,
    parameter logic [WORD_W-1:0] KEY         = 32'h00005AB9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] rd_data,
    output logic              rst_pulse,
    output logic              irq_pulse,
    output logic              ext_pulse
);
    localparam int N_OUT = 3;

    logic [CNT_W-1:0] reload_q;
    logic [LEN_W-1:0] len_q;
    ctrl_t            ctrl_q;
    logic             status_q;
    logic [CNT_W-1:0] cnt_q;
    logic             tick;
    logic             hit;
    logic             restart;
    logic [N_OUT-1:0] pulses;

    assign restart = wr_en && (addr == OFF_RESTART) && (wr_data == KEY);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reload_q <= RELOAD_INIT;
            len_q    <= LEN_INIT;
            ctrl_q   <= '0;
        end else if (wr_en) begin
            if (addr == OFF_RELOAD) reload_q <= wr_data[CNT_W-1:0];
            if (addr == OFF_LEN)    len_q    <= wr_data[LEN_W-1:0];
            if (addr == OFF_CTRL)   ctrl_q   <= ctrl_t'(wr_data[CTRL_W-1:0]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= 1'b0;
        end else if (hit) begin
            status_q <= 1'b1;
        end else if (wr_en && (addr == OFF_CLEAR) && wr_data[0]) begin
            status_q <= 1'b0;
        end
    end

    wdog_tick_gen #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .ext_clk(ext_clk),
        .use_ext(ctrl_q.clk_sel),
        .tick   (tick)
    );

    wdog_countdown #(
        .CNT_W(CNT_W),
        .INIT (RELOAD_INIT)
    ) u_count (
        .clk    (clk),
        .rst_n  (rst_n),
        .reload (reload_q),
        .restart(restart),
        .run    (ctrl_q.run),
        .tick   (tick),
        .count  (cnt_q),
        .hit    (hit)
    );

    wdog_pulse_fsm #(
        .LEN_W(LEN_W),
        .N_OUT(N_OUT)
    ) u_pulse (
        .clk    (clk),
        .rst_n  (rst_n),
        .fire   (hit),
        .len    (len_q),
        .en_mask({ctrl_q.ext_en, ctrl_q.irq_en, ctrl_q.rst_en}),
        .pulses (pulses)
    );

    assign rst_pulse = pulses[0];
    assign irq_pulse = pulses[1];
    assign ext_pulse = pulses[2];

    always_comb begin
        rd_data = '0;
        unique case (addr)
            OFF_COUNT:  rd_data[CNT_W-1:0]  = cnt_q;
            OFF_RELOAD: rd_data[CNT_W-1:0]  = reload_q;
            OFF_CTRL:   rd_data[CTRL_W-1:0] = ctrl_q;
            OFF_STATUS: rd_data[0]          = status_q;
            OFF_LEN:    rd_data[LEN_W-1:0]  = len_q;
            default:    rd_data = '0;
        endcase
    end

endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk
    import wdog_pkg::*;
#(
    parameter int                CNT_W = 32,
    parameter logic [WORD_W-1:0] KEY   = 32'h00005AB9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [WORD_W-1:0] wr_data,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  reload,
    input logic              run,
    input logic              tick,
    input logic              status,
    input logic              rst_pulse
);
    logic restart_w;
    logic reach_w;

    assign restart_w = wr_en && (addr == OFF_RESTART) && (wr_data == KEY);
    assign reach_w   = run && tick && (cnt == CNT_W'(1)) && !restart_w;

    p_restart_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        restart_w |=> (cnt == $past(reload)));

    p_bad_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFF_RESTART && wr_data != KEY && !run) |=> $stable(cnt));

    p_decrement_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && cnt != '0 && !restart_w) |=> (cnt == $past(cnt) - CNT_W'(1)));

    p_hold_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !restart_w) |=> $stable(cnt));

    p_zero_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0 && !restart_w) |=> (cnt == '0));

    p_status_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        reach_w |=> status);

    p_status_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFF_CLEAR && wr_data[0] && !reach_w) |=> !status);

    p_pulse_at_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_pulse) |-> (cnt == '0 || $past(restart_w)));

endmodule

bind wdog_timer wdog_timer_chk #(
    .CNT_W(CNT_W),
    .KEY  (KEY)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .addr     (addr),
    .wr_data  (wr_data),
    .cnt      (cnt_q),
    .reload   (reload_q),
    .run      (ctrl_q.run),
    .tick     (tick),
    .status   (status_q),
    .rst_pulse(rst_pulse)
);

// File: tb/tb_wdog_timer.sv
`timescale 1ns/1ps
module tb_wdog_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_clk = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        rst_pulse, irq_pulse, ext_pulse;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    localparam logic [31:0] KEY = 32'h00005AB9;

    always #2 clk = ~clk;

    wdog_timer dut (
        .clk(clk), .rst_n(rst_n), .ext_clk(ext_clk),
        .wr_en(wr_en), .addr(addr), .wr_data(wr_data), .rd_data(rd_data),
        .rst_pulse(rst_pulse), .irq_pulse(irq_pulse), .ext_pulse(ext_pulse)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        addr = a;
        #0.3;
        d = rd_data;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic ext_edges(input int n);
        for (int i = 0; i < n; i++) begin
            ext_clk = 1'b1; idle(3);
            ext_clk = 1'b0; idle(3);
        end
    endtask

    initial begin
        #(4 * 190000);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1: reset values
        rd(8'h04, v); chk("R1 reload", v, 32'h03EF1480);
        rd(8'h00, v); chk("R1 counter", v, 32'h03EF1480);
        rd(8'h18, v); chk("R1 length", v, 32'hFF);
        rd(8'h0C, v); chk("R1 control", v, 0);
        rd(8'h10, v); chk("R1 status", v, 0);
        chk("R1 pulses", {29'd0, ext_pulse, irq_pulse, rst_pulse}, 0);

        // R2: key checks with counting stopped
        wr(8'h04, 32'd100);
        wr(8'h08, KEY);
        rd(8'h00, v); chk("R2 key loads", v, 100);
        wr(8'h04, 32'd50);
        wr(8'h08, 32'h00005AB8);
        rd(8'h00, v); chk("R2 wrong key ignored", v, 100);
        wr(8'h08, 32'h00015AB9);
        rd(8'h00, v); chk("R2 upper bits must match", v, 100);
        wr(8'h08, KEY);
        rd(8'h00, v); chk("R2 key reloads", v, 50);

        // R3: disabled counter holds; R4: counter not writable
        idle(6);
        rd(8'h00, v); chk("R3 hold while disabled", v, 50);
        wr(8'h00, 32'd7);
        rd(8'h00, v); chk("R4 counter write ignored", v, 50);

        // R9: field widths, reserved and unmapped reads
        wr(8'h0C, 32'hFFFFFFE0 | 32'h1E);
        rd(8'h0C, v); chk("R9 control width", v, 32'h1E);
        wr(8'h0C, 32'h0);
        wr(8'h18, 32'hFFFFFF12);
        rd(8'h18, v); chk("R9 length width", v, 32'h12);
        rd(8'h1C, v); chk("R9 unmapped 0x1C", v, 0);
        rd(8'h05, v); chk("R9 unaligned 0x05", v, 0);
        rd(8'h40, v); chk("R9 unmapped 0x40", v, 0);
        rd(8'h08, v); chk("R9 restart reads zero", v, 0);

        // R3 R4 R5 R6 R7: sweep reload x pulse length x enable mask on bus clock
        for (int r = 1; r <= 5; r++) begin
            for (int l = 0; l <= 3; l++) begin
                int m;
                m = (r * 4 + l) % 8;
                wr(8'h0C, 32'h0);
                wr(8'h04, r);
                wr(8'h18, l);
                wr(8'h08, KEY);
                wr(8'h14, 32'h1);
                wr(8'h0C, {27'd0, 1'b0, m[2:0], 1'b1});
                rd(8'h00, v); chk("R3 start value", v, r);
                for (int k = 1; k <= r + l + 4; k++) begin
                    int ec;
                    int ep;
                    @(negedge clk);
                    ec = (k < r) ? (r - k) : 0;
                    ep = (k >= r && k <= r + l) ? m : 0;
                    rd(8'h00, v); chk("R3 R4 counter", v, ec);
                    rd(8'h10, v); chk("R5 status", v, (k >= r) ? 1 : 0);
                    chk("R6 R7 pulses", {29'd0, ext_pulse, irq_pulse, rst_pulse}, ep);
                end
            end
        end

        // R5: clear with 0 has no effect, with 1 clears
        wr(8'h14, 32'h0);
        rd(8'h10, v); chk("R5 clear with zero ignored", v, 1);
        wr(8'h14, 32'h1);
        rd(8'h10, v); chk("R5 clear", v, 0);
        // R4 R7: held at zero, no new status or pulse
        idle(10);
        rd(8'h00, v); chk("R4 held at zero", v, 0);
        rd(8'h10, v); chk("R7 no second expiry", v, 0);
        chk("R7 no second pulse", {29'd0, ext_pulse, irq_pulse, rst_pulse}, 0);

        // R8: external clock ticks
        wr(8'h0C, 32'h0);
        wr(8'h04, 32'd20);
        wr(8'h08, KEY);
        wr(8'h0C, 32'h11);
        idle(8);
        rd(8'h00, v); chk("R8 steady ext_clk holds", v, 20);
        ext_edges(7);
        idle(4);
        rd(8'h00, v); chk("R8 one step per edge", v, 13);
        // R8 latency: edge driven at negedge, sampled next posedge, decrement two edges later
        ext_clk = 1'b1;
        @(negedge clk);
        rd(8'h00, v); chk("R8 not yet after first sample", v, 13);
        @(negedge clk);
        rd(8'h00, v); chk("R8 not yet after second edge", v, 13);
        @(negedge clk);
        rd(8'h00, v); chk("R8 decrement on third edge", v, 12);
        idle(3);
        ext_clk = 1'b0;
        idle(3);
        // R8 R5: reach zero on external ticks
        wr(8'h14, 32'h1);
        wr(8'h04, 32'd2);
        wr(8'h08, KEY);
        ext_edges(2);
        idle(3);
        rd(8'h00, v); chk("R8 zero via ext", v, 0);
        rd(8'h10, v); chk("R5 status via ext", v, 1);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule